// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Controller

This block runs one bus cycle at a time on a 32-bit non-multiplexed bus with handshake termination. The core presents an address, a direction, an operand size and write data. The controller then drives the address, size, direction, address strobe and data strobe, and for writes the data lines. It waits for the cycle to end and returns the outcome in a single clock.

A cycle can end in four ways. The first is an external acknowledge on two active-low size-acknowledge inputs. The second is a bus-error input, which may arrive alone or with an acknowledge. The third is bus error together with halt, which asks for a retry. The fourth is a built-in acknowledge that fires after a programmed number of wait clocks, and this one has a fixed two-clock fast variant. Every external handshake input passes through a two-flop synchronizer. The result comes back as a one-clock done pulse together with the captured read data, the acknowledged port width and a status code.

Top module: `bus_cycle_ctl`

## Requirements
- R1: After reset, `as_n` and `ds_n` are high, `d_oe` is low and `done` is low.
- R2: A read cycle drives `as_n` and `ds_n` low on the same rising edge. On that edge it also drives `addr_o`, `size_o` (the request size; code 00 means 8-bit, 01 means 16-bit, 10 means 32-bit) and `rw_o` high.
- R3: On a write cycle, `ds_n` falls one clock after `as_n`. `d_oe` rises on the falling edge half a clock after `as_n` falls, and `d_o` carries all 32 bits of the write data.
- R4: An external acknowledge (`dsack_n` not equal to 11) ends the cycle. Because of the two-flop synchronizer, `done` rises on the third rising edge after the edge that lowered `as_n`. `port` reports 10 when `dsack_n`=00, 01 when `dsack_n`=01 and 00 when `dsack_n`=10.
- R5: On a read, `rdata` returns the value on `d_i` at the last falling edge before termination, and it is valid while `done` is high.
- R6: With `auto_en` set and no external termination, `done` rises on edge W+2 after the edge that asserted AS, where W is `auto_wait`. `port` then equals `auto_port`.
- R7: An external acknowledge that comes before the internal one ends the cycle at the external timing.
- R8: With `fast_en` set, `done` rises on the second rising edge after the edge that asserted AS.
- R9: A bus error (`berr_n` low) ends the cycle with status 01, both when it arrives alone and when it arrives together with an acknowledge.
- R10: Bus error and halt asserted together end the cycle with status 10 (retry). A normal completion gives status 00.
- R11: On the terminating edge, `as_n` and `ds_n` go high. `done` is high for exactly one clock. `d_oe` falls on the next falling edge.
- R12: A request raised while a cycle is running is ignored: the address does not change and no second cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start request, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_size | input | 2 | Operand size code |
| req_wdata | input | 32 | Write data |
| auto_en | input | 1 | Enable internal acknowledge |
| fast_en | input | 1 | Enable two-clock internal termination |
| auto_wait | input | 4 | Wait clocks for internal acknowledge |
| auto_port | input | 2 | Port code reported on internal acknowledge |
| addr_o | output | 32 | Bus address |
| size_o | output | 2 | Bus size code |
| rw_o | output | 1 | 1 = read, 0 = write |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| d_i | input | 32 | Bus data in |
| d_o | output | 32 | Bus data out |
| d_oe | output | 1 | Data bus drive enable |
| dsack_n | input | 2 | Size acknowledge pair, active low |
| berr_n | input | 1 | Bus error, active low |
| halt_n | input | 1 | Halt, active low |
| done | output | 1 | One-clock completion pulse |
| status | output | 2 | 00 ok, 01 error, 10 retry |
| port | output | 2 | Acknowledged port width code |
| rdata | output | 32 | Captured read data |

## Verification
The hardest case to reach from the ports is a race: an external acknowledge arriving while the internal wait counter is still counting. The outcome depends on how the synchronizer latency lines up against the counter. The bench programs a long internal wait and asserts the acknowledge half a clock after AS falls. It then measures that the cycle ends at the external latency. It also raises a second request in the middle of a cycle with a different address, and checks that the bus address holds and that the strobes stay high after completion.

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [DW-1:0]     req_wdata,
  input  logic              auto_en,
  input  logic              fast_en,
  input  logic [WAIT_W-1:0] auto_wait,
  input  logic [1:0]        auto_port,
  output logic [AW-1:0]     addr_o,
  output logic [1:0]        size_o,
  output logic              rw_o,
  output logic              as_n,
  output logic              ds_n,
  input  logic [DW-1:0]     d_i,
  output logic [DW-1:0]     d_o,
  output logic              d_oe,
  input  logic [1:0]        dsack_n,
  input  logic              berr_n,
  input  logic              halt_n,
  output logic              done,
  output logic [1:0]        status,
  output logic [1:0]        port,
  output logic [DW-1:0]     rdata
);
  localparam int CW = WAIT_W + 1;

  logic          run;
  logic [CW-1:0] cnt;
  logic [3:0]    sy1, sy2;
  logic [DW-1:0] rcap;

  wire ack_ext  = sy2[1:0] != 2'b11;
  wire bus_err  = !sy2[2];
  wire bus_halt = !sy2[3];
  wire hit_fast = fast_en && cnt == CW'(1);
  wire hit_auto = auto_en && cnt == CW'(auto_wait) + CW'(1);
  wire term     = run && (bus_err || ack_ext || hit_fast || hit_auto);

  wire [1:0] ext_port = (sy2[1:0] == 2'b00) ? 2'b10 :
                        (sy2[1:0] == 2'b01) ? 2'b01 : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '1;
      sy2 <= '1;
    end else begin
      sy1 <= {halt_n, berr_n, dsack_n};
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt    <= '0;
      addr_o <= '0;
      size_o <= 2'b00;
      rw_o   <= 1'b1;
      as_n   <= 1'b1;
      ds_n   <= 1'b1;
      d_o    <= '0;
      done   <= 1'b0;
      status <= 2'b00;
      port   <= 2'b00;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (req) begin
          run    <= 1'b1;
          cnt    <= '0;
          addr_o <= req_addr;
          size_o <= req_size;
          rw_o   <= !req_write;
          d_o    <= req_wdata;
          as_n   <= 1'b0;
          ds_n   <= req_write;
        end
      end else if (term) begin
        run    <= 1'b0;
        as_n   <= 1'b1;
        ds_n   <= 1'b1;
        done   <= 1'b1;
        rdata  <= rcap;
        status <= (bus_err && bus_halt) ? 2'b10 : bus_err ? 2'b01 : 2'b00;
        port   <= ack_ext ? ext_port : auto_port;
      end else begin
        if (cnt != '1) cnt <= cnt + CW'(1);
        if (!rw_o) ds_n <= 1'b0;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcap <= '0;
      d_oe <= 1'b0;
    end else begin
      d_oe <= run && !rw_o;
      if (run && rw_o) rcap <= d_i;
    end
  end
endmodule

// File: rtl/bus_cycle_ctl_chk.sv
module bus_cycle_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        as_n,
  input logic        ds_n,
  input logic        rw_o,
  input logic        d_oe,
  input logic        done,
  input logic [31:0] addr_o
);
  // R2
  read_ds_with_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_o && $fell(as_n)) |-> !ds_n);
  // R3
  write_ds_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_o && $fell(as_n)) |-> ds_n);
  // R3
  write_ds_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_o && $fell(as_n)) |=> !ds_n);
  // R3
  oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> !rw_o);
  // R11
  ds_within_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> ds_n);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_strobes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (as_n && ds_n));
  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !$fell(as_n)) |-> $stable(addr_o));
endmodule

bind bus_cycle_ctl bus_cycle_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .rw_o(rw_o),
  .d_oe(d_oe), .done(done), .addr_o(addr_o)
);

// File: tb/sim_bus_cycle_ctl.sv
`timescale 1ns/1ps
module sim_bus_cycle_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, d_i = '0;
  logic [1:0] req_size = 2'b10, auto_port = 2'b00;
  logic auto_en = 1'b0, fast_en = 1'b0;
  logic [3:0] auto_wait = '0;
  logic [1:0] dsack_n = 2'b11;
  logic berr_n = 1'b1, halt_n = 1'b1;
  logic [31:0] addr_o, d_o, rdata;
  logic [1:0] size_o, status, port;
  logic rw_o, as_n, ds_n, d_oe, done;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bus_cycle_ctl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .auto_en(auto_en), .fast_en(fast_en), .auto_wait(auto_wait),
    .auto_port(auto_port), .addr_o(addr_o), .size_o(size_o), .rw_o(rw_o),
    .as_n(as_n), .ds_n(ds_n), .d_i(d_i), .d_o(d_o), .d_oe(d_oe),
    .dsack_n(dsack_n), .berr_n(berr_n), .halt_n(halt_n), .done(done),
    .status(status), .port(port), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic run_cycle(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                           input logic [31:0] wd, input logic [1:0] ackn, input bit be,
                           input bit hl, input bit poke, output int n,
                           output logic [31:0] rd, output logic [1:0] st, output logic [1:0] pt);
    n = 0;
    req = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    while (n < 40) begin
      step();
      n++;
      if (n == 1) begin
        req = poke;
        if (poke) req_addr = ~a;
        dsack_n = ackn; berr_n = !be; halt_n = !hl;
        chk(!as_n && addr_o == a && size_o == sz && rw_o == !wr, "R2", {30'd0, as_n, rw_o}, {30'd0, 1'b0, !wr});
        if (!wr) chk(!ds_n, "R2", ds_n, 0);
        else     chk(ds_n, "R3", ds_n, 1);
      end
      if (n == 2 && !done) begin
        req = 1'b0; req_addr = a;
        if (poke) chk(addr_o == a, "R12", addr_o, a);
        if (wr) begin
          chk(!ds_n && d_oe, "R3", {30'd0, ds_n, d_oe}, 32'd1);
          chk(d_o == wd, "R3", d_o, wd);
        end
      end
      if (done) begin
        rd = rdata; st = status; pt = port;
        chk(as_n && ds_n && !d_oe, "R11", {29'd0, as_n, ds_n, d_oe}, 32'd6);
        dsack_n = 2'b11; berr_n = 1'b1; halt_n = 1'b1;
        break;
      end
    end
    step();
    chk(!done, "R11", done, 0);
    if (poke) begin
      step();
      chk(as_n, "R12", as_n, 1);
    end
    step();
  endtask

  task automatic t_reset();
    chk(as_n && ds_n && !d_oe && !done, "R1", {28'd0, as_n, ds_n, d_oe, done}, 32'hC);
  endtask

  task automatic t_read_sizes();
    int n; logic [31:0] rd; logic [1:0] st, pt;
    d_i = 32'hCAFE_1234;
    run_cycle(0, 2'b10, 32'h1000, 0, 2'b00, 0, 0, 0, n, rd, st, pt);
    chk(n == 4, "R4", n, 4);
    chk(pt == 2'b10, "R4", pt, 2);
    chk(rd == 32'hCAFE_1234, "R5", rd, 32'hCAFE_1234);
    chk(st == 2'b00, "R10", st, 0);
    d_i = 32'h0000_BEEF;
    run_cycle(0, 2'b01, 32'h2002, 0, 2'b01, 0, 0, 0, n, rd, st, pt);
    chk(pt == 2'b01, "R4", pt, 1);
    chk(rd == 32'h0000_BEEF, "R5", rd, 32'hBEEF);
    d_i = 32'h0000_005A;
    run_cycle(0, 2'b00, 32'h3003, 0, 2'b10, 0, 0, 0, n, rd, st, pt);
    chk(pt == 2'b00, "R4", pt, 0);
    chk(rd == 32'h5A, "R5", rd, 32'h5A);
  endtask

  task automatic t_write();
    int n; logic [31:0] rd; logic [1:0] st, pt;
    run_cycle(1, 2'b00, 32'h4000, 32'h8765_4321, 2'b00, 0, 0, 0, n, rd, st, pt);
    chk(n == 4 && st == 2'b00, "R3", n, 4);
  endtask

  task automatic t_auto();
    int n; logic [31:0] rd; logic [1:0] st, pt;
    auto_en = 1; auto_wait = 4'd3; auto_port = 2'b01;
    run_cycle(0, 2'b10, 32'h5000, 0, 2'b11, 0, 0, 0, n, rd, st, pt);
    chk(n == 6, "R6", n, 6);
    chk(pt == 2'b01, "R6", pt, 1);
    auto_wait = 4'd0;
    run_cycle(1, 2'b10, 32'h5004, 32'h1111_2222, 2'b11, 0, 0, 0, n, rd, st, pt);
    chk(n == 3, "R6", n, 3);
    auto_en = 0;
  endtask

  task automatic t_early_ack();
    int n; logic [31:0] rd; logic [1:0] st, pt;
    auto_en = 1; auto_wait = 4'd10; auto_port = 2'b00;
    run_cycle(0, 2'b10, 32'h6000, 0, 2'b00, 0, 0, 0, n, rd, st, pt);
    chk(n == 4, "R7", n, 4);
    chk(pt == 2'b10, "R7", pt, 2);
    auto_en = 0;
  endtask

  task automatic t_fast();
    int n; logic [31:0] rd; logic [1:0] st, pt;
    fast_en = 1; auto_port = 2'b10; d_i = 32'hA5A5_0F0F;
    run_cycle(0, 2'b10, 32'h7000, 0, 2'b11, 0, 0, 0, n, rd, st, pt);
    chk(n == 3, "R8", n, 3);
    chk(rd == 32'hA5A5_0F0F, "R8", rd, 32'hA5A5_0F0F);
    fast_en = 0;
  endtask

  task automatic t_errors();
    int n; logic [31:0] rd; logic [1:0] st, pt;
    run_cycle(0, 2'b10, 32'h8000, 0, 2'b11, 1, 0, 0, n, rd, st, pt);
    chk(st == 2'b01 && n == 4, "R9", st, 1);
    run_cycle(1, 2'b01, 32'h8004, 32'h55, 2'b00, 1, 0, 0, n, rd, st, pt);
    chk(st == 2'b01, "R9", st, 1);
    run_cycle(0, 2'b10, 32'h8008, 0, 2'b11, 1, 1, 0, n, rd, st, pt);
    chk(st == 2'b10, "R10", st, 2);
  endtask

  task automatic t_busy();
    int n; logic [31:0] rd; logic [1:0] st, pt;
    run_cycle(0, 2'b10, 32'h9000, 0, 2'b00, 0, 0, 1, n, rd, st, pt);
    chk(n == 4, "R12", n, 4);
  endtask

  initial begin
    fork
      begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_read_sizes();
        t_write();
        t_auto();
        t_early_ack();
        t_fast();
        t_errors();
        t_busy();
      end
      begin
        repeat (5000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule